// File: doc/BRIEF.md
# Stack Transfer Cycle Sequencer

This block produces the bus machine cycles for the instructions that move a 16-bit word to or from a stack that grows downward: push, pop, exchange with the stack top, call (always or on a condition), return (always or on a condition) and restart. A command comes in with an operation code, a condition flag, a data word, the program counter of the opcode, the stack pointer and a restart number. The block then emits one cycle record at a time. Each record gives the cycle kind, the address, the byte to write and the length of the cycle in T-states. When the last cycle has been taken, the block pulses `done` and presents the final stack pointer, the next program counter and the word it read.

Both the command input and the cycle output are valid/ready streams. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only when no command is in progress. A cycle record is consumed on an edge where `cyc_valid` and `cyc_ready` are both high. While `cyc_valid` is high and `cyc_ready` is low, every field of the record holds its value, and the sequencer does not advance. For read cycles, the memory side drives `cyc_rdata` in the same clock in which it accepts the record.

Opcode decoding, arithmetic and the memory itself are outside this block.

Top module: `stack_cycle_seq`

## Requirements
- R1: Push (code 0) emits a 5-T fetch at PC, then a 3-T high-byte write at SP-1 and a 3-T low-byte write at SP-2. The final SP is SP-2 and the next PC is PC+1.
- R2: Pop (code 1) emits a 4-T fetch, then a 3-T low-byte read at SP and a 3-T high-byte read at SP+1. The result word is {high, low}, the final SP is SP+2 and the next PC is PC+1.
- R3: Exchange with stack top (code 2) emits the following cycles in order: fetch 4 T, low read at SP 3 T, high read at SP+1 4 T, high write of the input word at SP+1 3 T, low write at SP 5 T. The final SP equals the starting SP, and the result word is the old stack word.
- R4: Call (code 3) emits a 4-T fetch, a 3-T operand-low read at PC+1 and a 4-T operand-high read at PC+2. It then pushes PC+3 with two 3-T writes at SP-1 (high) and SP-2 (low). The next PC is the operand word.
- R5: Conditional call (code 4) with the condition true behaves as in R4. With the condition false, it ends after a 3-T operand-high read, SP is unchanged and the next PC is PC+3.
- R6: Return (code 5) emits a 4-T fetch and the two 3-T reads of R2, and the next PC is the popped word. Conditional return (code 6) uses a 5-T fetch, and performs the reads only if the condition is true. Otherwise SP is unchanged and the next PC is PC+1.
- R7: Restart (code 7) emits a 5-T fetch and pushes PC+1 as in R1. The next PC is the restart number times 8.
- R8: The low byte of a stack word sits at the lower address, and all stack addresses and the final SP wrap modulo 65536.
- R9: While `cyc_valid` is high and `cyc_ready` is low, kind, address, write data and length stay unchanged. Each accepted record appears exactly once.
- R10: `cmd_ready` is high exactly when no command is in progress. `done` is a one-cycle pulse after the last accepted cycle, and `res_sp`, `res_pc` and `res_word` are valid while `done` is high.
- R11: Cycle kind codes are: 0 fetch, 1 operand low read, 2 operand high read, 3 stack low read, 4 stack high read, 5 stack high write, 6 stack low write. Every command starts with a fetch, and every cycle is 3 to 5 T long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command accepted on this edge |
| cmd_op | input | 3 | Operation code (R1 to R7) |
| cmd_cond | input | 1 | Condition flag for conditional call and return |
| cmd_word | input | 16 | Word to push (push) or to swap in (exchange) |
| cmd_pc | input | 16 | Address of the opcode |
| cmd_sp | input | 16 | Stack pointer at the start |
| cmd_vec | input | 3 | Restart number |
| cyc_valid | output | 1 | Cycle record valid |
| cyc_ready | input | 1 | Cycle record accepted |
| cyc_kind | output | 3 | Cycle kind (R11) |
| cyc_addr | output | 16 | Cycle address |
| cyc_wdata | output | 8 | Byte to write on write cycles |
| cyc_tstates | output | 3 | Cycle length in T-states |
| cyc_rdata | input | 8 | Read byte, valid with the accept of a read cycle |
| done | output | 1 | One-cycle completion pulse |
| res_sp | output | 16 | Final stack pointer |
| res_pc | output | 16 | Next program counter |
| res_word | output | 16 | Word read from the stack or operands |

## Verification
The assertions check on every cycle that a stalled record holds still and that `done` is a single pulse. They also check that a busy block never signals ready, that each command opens with a fetch, that cycle lengths stay within 3 to 5 T, and that a false condition suppresses the stack and push cycles of conditional calls and returns. Only the bench scenarios can show the full ordered trace for each command: the addresses after wrap-around at 0x0000/0xFFFF, the bytes written, the data read back through the memory model, and the final SP and PC values. These scenarios are run with and without back-pressure.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int unsigned T_W    = 3;
  localparam int unsigned STEP_W = 3;

  typedef enum logic [2:0] {
    OP_PUSH  = 3'd0,
    OP_POP   = 3'd1,
    OP_EXSP  = 3'd2,
    OP_CALL  = 3'd3,
    OP_CALLC = 3'd4,
    OP_RET   = 3'd5,
    OP_RETC  = 3'd6,
    OP_RST   = 3'd7
  } stk_op_e;

  typedef enum logic [2:0] {
    CK_FETCH = 3'd0,
    CK_OPL   = 3'd1,
    CK_OPH   = 3'd2,
    CK_SRL   = 3'd3,
    CK_SRH   = 3'd4,
    CK_SWH   = 3'd5,
    CK_SWL   = 3'd6
  } cyc_kind_e;

  typedef enum logic [1:0] {
    SP_KEEP    = 2'd0,
    SP_PREDEC  = 2'd1,
    SP_POSTINC = 2'd2
  } sp_act_e;

  typedef struct packed {
    cyc_kind_e       kind;
    logic [T_W-1:0]  tstates;
    sp_act_e         spact;
    logic            last;
  } step_t;
endpackage

// File: rtl/stk_step_table.sv
module stk_step_table
  import stk_pkg::*;
(
  input  stk_op_e            op,
  input  logic [STEP_W-1:0]  step,
  input  logic               cond,
  output step_t              ent
);
  function automatic step_t mk(cyc_kind_e k, int unsigned t, sp_act_e a, logic l);
    step_t s;
    s.kind    = k;
    s.tstates = T_W'(t);
    s.spact   = a;
    s.last    = l;
    return s;
  endfunction

  always_comb begin
    ent = mk(CK_FETCH, 4, SP_KEEP, 1'b1);
    unique case (op)
      OP_PUSH, OP_RST: begin
        case (step)
          3'd0:    ent = mk(CK_FETCH, 5, SP_KEEP, 1'b0);
          3'd1:    ent = mk(CK_SWH, 3, SP_PREDEC, 1'b0);
          default: ent = mk(CK_SWL, 3, SP_PREDEC, 1'b1);
        endcase
      end
      OP_POP, OP_RET, OP_RETC: begin
        case (step)
          3'd0: begin
            if (op == OP_RETC) ent = mk(CK_FETCH, 5, SP_KEEP, !cond);
            else               ent = mk(CK_FETCH, 4, SP_KEEP, 1'b0);
          end
          3'd1:    ent = mk(CK_SRL, 3, SP_POSTINC, 1'b0);
          default: ent = mk(CK_SRH, 3, SP_POSTINC, 1'b1);
        endcase
      end
      OP_EXSP: begin
        case (step)
          3'd0:    ent = mk(CK_FETCH, 4, SP_KEEP, 1'b0);
          3'd1:    ent = mk(CK_SRL, 3, SP_POSTINC, 1'b0);
          3'd2:    ent = mk(CK_SRH, 4, SP_KEEP, 1'b0);
          3'd3:    ent = mk(CK_SWH, 3, SP_KEEP, 1'b0);
          default: ent = mk(CK_SWL, 5, SP_PREDEC, 1'b1);
        endcase
      end
      OP_CALL, OP_CALLC: begin
        case (step)
          3'd0: ent = mk(CK_FETCH, 4, SP_KEEP, 1'b0);
          3'd1: ent = mk(CK_OPL, 3, SP_KEEP, 1'b0);
          3'd2: begin
            if (op == OP_CALLC && !cond) ent = mk(CK_OPH, 3, SP_KEEP, 1'b1);
            else                         ent = mk(CK_OPH, 4, SP_KEEP, 1'b0);
          end
          3'd3:    ent = mk(CK_SWH, 3, SP_PREDEC, 1'b0);
          default: ent = mk(CK_SWL, 3, SP_PREDEC, 1'b1);
        endcase
      end
      default: ent = mk(CK_FETCH, 4, SP_KEEP, 1'b1);
    endcase
  end
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr
  import stk_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step_en,
  input  sp_act_e           act,
  output logic [ADDR_W-1:0] sp_q,
  output logic [ADDR_W-1:0] bus_addr
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] sp_dec;
  assign sp_dec   = sp_q - ONE;
  assign bus_addr = (act == SP_PREDEC) ? sp_dec : sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else if (load) begin
      sp_q <= load_val;
    end else if (step_en) begin
      case (act)
        SP_PREDEC:  sp_q <= sp_dec;
        SP_POSTINC: sp_q <= sp_q + ONE;
        default:    sp_q <= sp_q;
      endcase
    end
  end

  // R8: a step without a pointer action leaves the pointer alone
  a_r8_keep_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load && act == SP_KEEP) |=> $stable(sp_q));
endmodule

// File: rtl/stack_cycle_seq.sv
module stack_cycle_seq
  import stk_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [2:0]          cmd_op,
  input  logic                cmd_cond,
  input  logic [2*BYTE_W-1:0] cmd_word,
  input  logic [ADDR_W-1:0]   cmd_pc,
  input  logic [ADDR_W-1:0]   cmd_sp,
  input  logic [2:0]          cmd_vec,
  output logic                cyc_valid,
  input  logic                cyc_ready,
  output logic [2:0]          cyc_kind,
  output logic [ADDR_W-1:0]   cyc_addr,
  output logic [BYTE_W-1:0]   cyc_wdata,
  output logic [T_W-1:0]      cyc_tstates,
  input  logic [BYTE_W-1:0]   cyc_rdata,
  output logic                done,
  output logic [ADDR_W-1:0]   res_sp,
  output logic [ADDR_W-1:0]   res_pc,
  output logic [2*BYTE_W-1:0] res_word
);
  localparam int unsigned WORD_W = 2 * BYTE_W;
  localparam int unsigned VEC_SH = 3;

  logic                busy_q, done_q;
  logic [STEP_W-1:0]   step_q;
  stk_op_e             op_q;
  logic                cond_q;
  logic [WORD_W-1:0]   word_q, got_q, push_word;
  logic [ADDR_W-1:0]   pc_q, sp_addr;
  logic [2:0]          vec_q;
  step_t               ent;
  logic                accept, fire;

  assign cmd_ready = !busy_q;
  assign cyc_valid = busy_q;
  assign accept    = cmd_valid && cmd_ready;
  assign fire      = cyc_valid && cyc_ready;

  stk_step_table u_table (
    .op   (op_q),
    .step (step_q),
    .cond (cond_q),
    .ent  (ent)
  );

  stk_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (cmd_sp),
    .step_en  (fire),
    .act      (ent.spact),
    .sp_q     (res_sp),
    .bus_addr (sp_addr)
  );

  // Word pushed by push-type commands
  always_comb begin
    case (op_q)
      OP_CALL, OP_CALLC: push_word = WORD_W'(pc_q + ADDR_W'(3));
      OP_RST:            push_word = WORD_W'(pc_q + ADDR_W'(1));
      default:           push_word = word_q;
    endcase
  end

  // Cycle record fields
  always_comb begin
    cyc_kind    = ent.kind;
    cyc_tstates = ent.tstates;
    cyc_wdata   = '0;
    case (ent.kind)
      CK_FETCH: cyc_addr = pc_q;
      CK_OPL:   cyc_addr = pc_q + ADDR_W'(1);
      CK_OPH:   cyc_addr = pc_q + ADDR_W'(2);
      default:  cyc_addr = sp_addr;
    endcase
    if (ent.kind == CK_SWH) cyc_wdata = push_word[WORD_W-1:BYTE_W];
    if (ent.kind == CK_SWL) cyc_wdata = push_word[BYTE_W-1:0];
  end

  // Command and step control
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
      op_q   <= OP_PUSH;
      cond_q <= 1'b0;
      word_q <= '0;
      pc_q   <= '0;
      vec_q  <= '0;
      got_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        step_q <= '0;
        op_q   <= stk_op_e'(cmd_op);
        cond_q <= cmd_cond;
        word_q <= cmd_word;
        pc_q   <= cmd_pc;
        vec_q  <= cmd_vec;
      end else if (fire) begin
        if (ent.kind == CK_OPL || ent.kind == CK_SRL) got_q[BYTE_W-1:0]      <= cyc_rdata;
        if (ent.kind == CK_OPH || ent.kind == CK_SRH) got_q[WORD_W-1:BYTE_W] <= cyc_rdata;
        if (ent.last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          step_q <= step_q + STEP_W'(1);
        end
      end
    end
  end

  // Results
  always_comb begin
    case (op_q)
      OP_CALL, OP_RET: res_pc = ADDR_W'(got_q);
      OP_CALLC:        res_pc = cond_q ? ADDR_W'(got_q) : pc_q + ADDR_W'(3);
      OP_RETC:         res_pc = cond_q ? ADDR_W'(got_q) : pc_q + ADDR_W'(1);
      OP_RST:          res_pc = ADDR_W'(vec_q) << VEC_SH;
      default:         res_pc = pc_q + ADDR_W'(1);
    endcase
  end

  assign done     = done_q;
  assign res_word = got_q;

  // R9: a stalled record holds every field
  a_r9_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !cyc_ready) |=> (cyc_valid && $stable(cyc_kind) && $stable(cyc_addr)
                                   && $stable(cyc_wdata) && $stable(cyc_tstates)));
  // R10: completion is a single pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10: no new command while cycles are pending
  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> !cmd_ready);
  // R11: every command opens with a fetch
  a_r11_fetch_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cyc_valid) |-> cyc_kind == 3'(CK_FETCH));
  // R11: lengths within 3..5 T
  a_r11_tstate_range: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> (cyc_tstates >= 3'd3 && cyc_tstates <= 3'd5));
  // R5: false condition keeps a conditional call off the stack
  a_r5_callc_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && op_q == OP_CALLC && !cond_q) |-> cyc_kind <= 3'(CK_OPH));
  // R6: false condition leaves a conditional return at its fetch
  a_r6_retc_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && op_q == OP_RETC && !cond_q) |-> cyc_kind == 3'(CK_FETCH));
endmodule

// File: tb/tb_stack_cycle_seq.sv
module tb_stack_cycle_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic        cmd_cond = 1'b0;
  logic [15:0] cmd_word = '0, cmd_pc = '0, cmd_sp = '0;
  logic [2:0]  cmd_vec = '0;
  logic        cyc_valid, cyc_ready = 1'b1;
  logic [2:0]  cyc_kind, cyc_tstates;
  logic [15:0] cyc_addr;
  logic [7:0]  cyc_wdata, cyc_rdata;
  logic        done;
  logic [15:0] res_sp, res_pc, res_word;

  int n_chk = 0, n_fail = 0;
  bit stall = 1'b0;

  typedef struct packed {
    logic [2:0] kind; logic [15:0] addr; logic [7:0] wd; logic [2:0] t;
  } rec_t;
  rec_t  exp_q[$];
  string req_q[$];

  always #2 clk = ~clk;

  stack_cycle_seq dut (.*);

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  assign cyc_rdata = pat(cyc_addr);

  always @(posedge clk) #1 cyc_ready <= stall ? ($urandom % 3 != 0) : 1'b1;

  task automatic check(input string rq, input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic ex(input string rq, input logic [2:0] k, input logic [15:0] a,
                    input logic [7:0] d, input logic [2:0] t);
    exp_q.push_back({k, a, d, t});
    req_q.push_back(rq);
  endtask

  // Monitor: compares accepted records and stall stability (R9)
  rec_t prev; bit prev_stall = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      rec_t cur;
      cur = {cyc_kind, cyc_addr, ((cyc_kind >= 3'd5) ? cyc_wdata : 8'h00), cyc_tstates};
      if (prev_stall)
        check("R9", cyc_valid && cur == prev, "stalled record", 64'(cur), 64'(prev));
      if (cyc_valid && cyc_ready) begin
        if (exp_q.size() == 0) check("R11", 1'b0, "unexpected cycle", 64'(cur), 64'h0);
        else begin
          rec_t e; string r;
          e = exp_q.pop_front(); r = req_q.pop_front();
          check(r, cur == e, "cycle {kind,addr,wdata,t}", 64'(cur), 64'(e));
        end
      end
      prev_stall = cyc_valid && !cyc_ready;
      prev = cur;
    end
  end

  task automatic run(input string rq, input logic [2:0] op, input bit c,
                     input logic [15:0] w, input logic [15:0] pc,
                     input logic [15:0] sp, input logic [2:0] v);
    logic [15:0] xsp, xpc, xw, pw;
    bit chk_w = 1'b0;
    xw = {pat(sp + 16'd1), pat(sp)};
    case (op)
      3'd0, 3'd7: begin // R1 push, R7 restart
        pw = (op == 3'd7) ? pc + 16'd1 : w;
        ex(rq, 3'd0, pc, 8'h00, 3'd5);
        ex(rq, 3'd5, sp - 16'd1, pw[15:8], 3'd3);
        ex(rq, 3'd6, sp - 16'd2, pw[7:0], 3'd3);
        xsp = sp - 16'd2;
        xpc = (op == 3'd7) ? {10'd0, v, 3'd0} : pc + 16'd1;
      end
      3'd1, 3'd5, 3'd6: begin // R2 pop, R6 returns
        ex(rq, 3'd0, pc, 8'h00, (op == 3'd6) ? 3'd5 : 3'd4);
        if (op != 3'd6 || c) begin
          ex(rq, 3'd3, sp, 8'h00, 3'd3);
          ex(rq, 3'd4, sp + 16'd1, 8'h00, 3'd3);
          xsp = sp + 16'd2;
          xpc = (op == 3'd1) ? pc + 16'd1 : xw;
          chk_w = 1'b1;
        end else begin
          xsp = sp; xpc = pc + 16'd1;
        end
      end
      3'd2: begin // R3 exchange
        ex(rq, 3'd0, pc, 8'h00, 3'd4);
        ex(rq, 3'd3, sp, 8'h00, 3'd3);
        ex(rq, 3'd4, sp + 16'd1, 8'h00, 3'd4);
        ex(rq, 3'd5, sp + 16'd1, w[15:8], 3'd3);
        ex(rq, 3'd6, sp, w[7:0], 3'd5);
        xsp = sp; xpc = pc + 16'd1; chk_w = 1'b1;
      end
      default: begin // R4 call, R5 conditional call
        pw = pc + 16'd3;
        ex(rq, 3'd0, pc, 8'h00, 3'd4);
        ex(rq, 3'd1, pc + 16'd1, 8'h00, 3'd3);
        if (op == 3'd3 || c) begin
          ex(rq, 3'd2, pc + 16'd2, 8'h00, 3'd4);
          ex(rq, 3'd5, sp - 16'd1, pw[15:8], 3'd3);
          ex(rq, 3'd6, sp - 16'd2, pw[7:0], 3'd3);
          xsp = sp - 16'd2;
          xpc = {pat(pc + 16'd2), pat(pc + 16'd1)};
        end else begin
          ex(rq, 3'd2, pc + 16'd2, 8'h00, 3'd3);
          xsp = sp; xpc = pc + 16'd3;
        end
      end
    endcase
    forever begin @(negedge clk); if (cmd_ready) break; end
    cmd_valid = 1'b1; cmd_op = op; cmd_cond = c; cmd_word = w;
    cmd_pc = pc; cmd_sp = sp; cmd_vec = v;
    @(posedge clk); #1 cmd_valid = 1'b0;
    forever begin @(negedge clk); if (done) break; end
    check(rq, exp_q.size() == 0, "cycles missing at done", 64'(exp_q.size()), 64'h0);
    check(rq, res_sp == xsp, "res_sp", 64'(res_sp), 64'(xsp));
    check(rq, res_pc == xpc, "res_pc", 64'(res_pc), 64'(xpc));
    if (chk_w) check(rq, res_word == xw, "res_word", 64'(res_word), 64'(xw));
    @(negedge clk);
    check("R10", !done && cmd_ready, "done pulse / ready", {62'd0, done, cmd_ready}, 64'h1);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", cmd_ready && !cyc_valid && !done, "reset idle", {61'd0, cmd_ready, cyc_valid, done}, 64'h4);
    rst_n = 1'b1;
    for (int pass = 0; pass < 2; pass++) begin
      stall = (pass == 1);
      run("R1",  3'd0, 1'b0, 16'h1234, 16'h0100, 16'h8000, 3'd0);
      run("R2",  3'd1, 1'b0, 16'h0000, 16'h0101, 16'h7FFE, 3'd0);
      run("R8",  3'd0, 1'b0, 16'hA1B2, 16'h0200, 16'h0001, 3'd0);
      run("R8",  3'd1, 1'b0, 16'h0000, 16'h0201, 16'hFFFF, 3'd0);
      run("R3",  3'd2, 1'b0, 16'hBEEF, 16'h0300, 16'h4000, 3'd0);
      run("R4",  3'd3, 1'b0, 16'h0000, 16'h1000, 16'h9000, 3'd0);
      run("R5",  3'd4, 1'b0, 16'h0000, 16'h1100, 16'h9000, 3'd0);
      run("R5",  3'd4, 1'b1, 16'h0000, 16'h1200, 16'h0000, 3'd0);
      run("R6",  3'd5, 1'b0, 16'h0000, 16'h1300, 16'h6000, 3'd0);
      run("R6",  3'd6, 1'b0, 16'h0000, 16'h1400, 16'h6000, 3'd0);
      run("R6",  3'd6, 1'b1, 16'h0000, 16'h1500, 16'hFFFF, 3'd0);
      run("R7",  3'd7, 1'b0, 16'h0000, 16'h2222, 16'h5000, 3'd5);
      run("R11", 3'd7, 1'b0, 16'h0000, 16'hFFFF, 16'h0002, 3'd7);
    end
    finish_run();
  end
endmodule